// File: doc/BRIEF.md
# Indirect Codec Register Access Bridge

This block lets a bus host reach a bank of byte-wide codec control registers through two 32-bit windows. The first window is a command word that carries a write-request flag, a register address and a data byte. The second window is a read-back word that carries the selected register's byte and a live interrupt indication. A host write to the command window with the request flag set starts a write. The flag then reads back as a busy indicator until the byte reaches the bank. A host write with the flag clear only moves the address pointer, and the selected byte appears in the read-back window after a fixed latency.

The bank holds 28 entries with fixed reset values. Two test entries and every address past the end of the bank are blocked. A status entry holds two sticky ramp-completion flags. A modelled output stage sets these flags with one-cycle pulses, and the host clears them by writing zero.

Top module: `codec_reg_bridge`

## Requirements
- R1: The command window reads back as: bit 16 = busy, bits 14:8 = the current register address, bits 7:0 = the current data byte. Bits 31:17 and bit 15 read as zero.
- R2: An accepted command with bit 16 set makes busy read 1 from the cycle after acceptance. The byte is committed to the bank on the 4th clock edge after acceptance, and busy reads 0 from that edge on.
- R3: While busy is 1, a command-window write is ignored completely. Address, data byte and busy are unchanged, and the ignored write reaches no register.
- R4: An accepted command with bit 16 clear loads the address and starts a read. The read-back window bits 7:0 keep their old value through the 5th edge after acceptance and show the selected register from the 6th edge on.
- R5: After reset, busy, address and data byte are 0 and the read-back window is 0. The bank entries 0..27 hold, in address order, 0C AA 78 00 00 FF 03 51 3F 00 00 04 04 04 04 04 04 0A 0A 00 00 00 C0 34 07 44 1F 00.
- R6: Addresses 20, 21 and 28..127 are blocked. Reads of them return 0x00, and writes to them change no register.
- R7: Entry 9 is the status register. A one-cycle pulse on the ramp-up input sets its bit 3, and a pulse on the ramp-down input sets its bit 2. A set flag holds until a host write stores 0 into that bit. A pulse in the same cycle as a commit to entry 9 wins over the written 0.
- R8: Read-back window bit 8 is 1 exactly when bit 3 or bit 2 of entry 9 is set. It follows the register at once, without waiting for a read. Bits 31:9 read as zero.
- R9: Between accepted commands, read-back bits 7:0 stay stable once the read latency has elapsed. Repeated fetches return the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Host write strobe for the command window |
| cmdWdata | input | 32 | Command word written by the host |
| cmdRdata | output | 32 | Command window read-back (busy, address, data byte) |
| dataRdata | output | 32 | Read-back window (interrupt bit 8, register byte 7:0) |
| rampUpPulse | input | 1 | One-cycle pulse: output stage finished ramping up |
| rampDnPulse | input | 1 | One-cycle pulse: output stage finished ramping down |

## Verification
The checker watches the busy flag on every cycle. Busy may only rise after a request carrying the write flag, and it must never last longer than the commit latency. Command fields must not move while busy, the reserved bits must read zero, the interrupt bit may rise only after a ramp pulse, and the read-back byte must stay stable once the read latency has passed. The bench scenarios are the only place to show that the bank contents are right: reset defaults, committed values, discarded writes to blocked addresses, the exact edge at which read data turns over, and the set-wins case on the status register.

// File: rtl/codec_bridge_pkg.sv
package codec_bridge_pkg;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic acceptCmd;   // command word taken into the address/data fields
    logic commit;      // pending write byte goes into the bank
    logic capture;     // selected register is latched into the read-back byte
  } bridge_strobe_t;

  // Power-on contents of the register bank
  function automatic logic [7:0] bankDefault(input int idx);
    case (idx)
      0:  return 8'h0C;
      1:  return 8'hAA;
      2:  return 8'h78;
      5:  return 8'hFF;
      6:  return 8'h03;
      7:  return 8'h51;
      8:  return 8'h3F;
      11, 12, 13, 14, 15, 16: return 8'h04;
      17, 18: return 8'h0A;
      22: return 8'hC0;
      23: return 8'h34;
      24: return 8'h07;
      25: return 8'h44;
      26: return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/codec_bridge_ctrl.sv
module codec_bridge_ctrl
  import codec_bridge_pkg::*;
#(
  parameter int COMMIT_LAT = 4,
  parameter int READ_LAT   = 6
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cmdWrEn,
  input  logic           reqBit,
  output logic           busy,
  output bridge_strobe_t strobe
);
  localparam int CW = $clog2(COMMIT_LAT + 1);
  localparam int RW = $clog2(READ_LAT + 1);

  logic [CW-1:0] commitCnt;
  logic [RW-1:0] readCnt;
  logic          readPend;
  logic          accept;

  assign accept = cmdWrEn & ~busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      commitCnt <= '0;
    end else if (accept && reqBit) begin
      busy      <= 1'b1;
      commitCnt <= CW'(COMMIT_LAT - 1);
    end else if (busy) begin
      if (commitCnt == '0) busy <= 1'b0;
      else                 commitCnt <= commitCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readPend <= 1'b0;
      readCnt  <= '0;
    end else if (accept) begin
      readPend <= 1'b1;
      readCnt  <= RW'(READ_LAT - 1);
    end else if (readPend) begin
      if (readCnt == '0) readPend <= 1'b0;
      else               readCnt  <= readCnt - 1'b1;
    end
  end

  always_comb begin
    strobe.acceptCmd = accept;
    strobe.commit    = busy & (commitCnt == '0);
    strobe.capture   = readPend & (readCnt == '0);
  end

endmodule

// File: rtl/codec_bridge_dp.sv
module codec_bridge_dp
  import codec_bridge_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int NUM_REGS    = 28,
  parameter int STATUS_ADDR = 9,
  parameter int RAMP_UP_BIT = 3,
  parameter int RAMP_DN_BIT = 2,
  parameter int TEST_ADDR_A = 20,
  parameter int TEST_ADDR_B = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  bridge_strobe_t    strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rampUpPulse,
  input  logic              rampDnPulse,
  output logic [ADDR_W-1:0] addrQ,
  output logic [DATA_W-1:0] dinQ,
  output logic [DATA_W-1:0] dataQ,
  output logic              irq
);
  logic [DATA_W-1:0] bank [NUM_REGS];
  logic [DATA_W-1:0] rdSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dinQ  <= '0;
    end else if (strobe.acceptCmd) begin
      addrQ <= wrAddr;
      dinQ  <= wrData;
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
    if (i == TEST_ADDR_A || i == TEST_ADDR_B) begin : g_blocked
      assign bank[i] = '0;
    end else begin : g_live
      logic [DATA_W-1:0] setMask;
      logic              hit;
      if (i == STATUS_ADDR) begin : g_status
        always_comb begin
          setMask = '0;
          setMask[RAMP_UP_BIT] = rampUpPulse;
          setMask[RAMP_DN_BIT] = rampDnPulse;
        end
      end else begin : g_plain
        assign setMask = '0;
      end
      assign hit = strobe.commit && (addrQ == ADDR_W'(i));
      always_ff @(posedge clk) begin
        if (!rstN) bank[i] <= DATA_W'(bankDefault(i));
        else       bank[i] <= (hit ? dinQ : bank[i]) | setMask;
      end
    end
  end

  always_comb begin
    rdSel = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addrQ == ADDR_W'(i)) rdSel = bank[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN)               dataQ <= '0;
    else if (strobe.capture) dataQ <= rdSel;
  end

  assign irq = bank[STATUS_ADDR][RAMP_UP_BIT] | bank[STATUS_ADDR][RAMP_DN_BIT];

endmodule

// File: rtl/codec_reg_bridge.sv
module codec_reg_bridge
  import codec_bridge_pkg::*;
#(
  parameter int BUS_W       = 32,
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int NUM_REGS    = 28,
  parameter int COMMIT_LAT  = 4,
  parameter int READ_LAT    = 6,
  parameter int STATUS_ADDR = 9,
  parameter int RAMP_UP_BIT = 3,
  parameter int RAMP_DN_BIT = 2,
  parameter int TEST_ADDR_A = 20,
  parameter int TEST_ADDR_B = 21
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWrEn,
  input  logic [BUS_W-1:0] cmdWdata,
  output logic [BUS_W-1:0] cmdRdata,
  output logic [BUS_W-1:0] dataRdata,
  input  logic             rampUpPulse,
  input  logic             rampDnPulse
);
  localparam int ADDR_LSB = 8;
  localparam int REQ_BIT  = 16;
  localparam int IRQ_BIT  = DATA_W;

  bridge_strobe_t    strobe;
  logic              busy;
  logic              irq;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dinQ;
  logic [DATA_W-1:0] dataQ;

  codec_bridge_ctrl #(
    .COMMIT_LAT(COMMIT_LAT),
    .READ_LAT  (READ_LAT)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .cmdWrEn(cmdWrEn),
    .reqBit (cmdWdata[REQ_BIT]),
    .busy   (busy),
    .strobe (strobe)
  );

  codec_bridge_dp #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .NUM_REGS   (NUM_REGS),
    .STATUS_ADDR(STATUS_ADDR),
    .RAMP_UP_BIT(RAMP_UP_BIT),
    .RAMP_DN_BIT(RAMP_DN_BIT),
    .TEST_ADDR_A(TEST_ADDR_A),
    .TEST_ADDR_B(TEST_ADDR_B)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrAddr     (cmdWdata[ADDR_LSB +: ADDR_W]),
    .wrData     (cmdWdata[DATA_W-1:0]),
    .rampUpPulse(rampUpPulse),
    .rampDnPulse(rampDnPulse),
    .addrQ      (addrQ),
    .dinQ       (dinQ),
    .dataQ      (dataQ),
    .irq        (irq)
  );

  always_comb begin
    cmdRdata = '0;
    cmdRdata[REQ_BIT] = busy;
    cmdRdata[ADDR_LSB +: ADDR_W] = addrQ;
    cmdRdata[DATA_W-1:0] = dinQ;
    dataRdata = '0;
    dataRdata[IRQ_BIT] = irq;
    dataRdata[DATA_W-1:0] = dataQ;
  end

endmodule

// File: rtl/codec_bridge_chk.sv
module codec_bridge_chk #(
  parameter int COMMIT_LAT = 4,
  parameter int READ_LAT   = 6
) (
  input logic        clk,
  input logic        rstN,
  input logic        cmdWrEn,
  input logic [31:0] cmdWdata,
  input logic [31:0] cmdRdata,
  input logic [31:0] dataRdata,
  input logic        rampUpPulse,
  input logic        rampDnPulse
);
  logic       busy;
  logic [7:0] busyLen;
  logic [7:0] sinceAcc;

  assign busy = cmdRdata[16];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyLen  <= '0;
      sinceAcc <= '0;
    end else begin
      busyLen <= busy ? busyLen + 1'b1 : '0;
      if (cmdWrEn && !busy)    sinceAcc <= '0;
      else if (sinceAcc != '1) sinceAcc <= sinceAcc + 1'b1;
    end
  end

  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRdata[31:17] == '0) && !cmdRdata[15]);

  // R2
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdWrEn && cmdWdata[16]));

  // R2
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyLen < 8'(COMMIT_LAT)));

  // R3
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdWrEn) |=> $stable(cmdRdata[14:0]));

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataRdata[8]) |-> $past(rampUpPulse || rampDnPulse));

  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataRdata[31:9] == '0);

  // R9
  data_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceAcc > 8'(READ_LAT)) |-> $stable(dataRdata[7:0]));

endmodule

bind codec_reg_bridge codec_bridge_chk #(
  .COMMIT_LAT(COMMIT_LAT),
  .READ_LAT  (READ_LAT)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cmdWrEn    (cmdWrEn),
  .cmdWdata   (cmdWdata),
  .cmdRdata   (cmdRdata),
  .dataRdata  (dataRdata),
  .rampUpPulse(rampUpPulse),
  .rampDnPulse(rampDnPulse)
);

// File: tb/tb_codec_reg_bridge.sv
module tb_codec_reg_bridge;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWrEn = 1'b0;
  logic [31:0] cmdWdata = '0;
  logic [31:0] cmdRdata;
  logic [31:0] dataRdata;
  logic        rampUpPulse = 1'b0;
  logic        rampDnPulse = 1'b0;

  int testCount = 0;
  int failCount = 0;

  logic [7:0] defaults [28] = '{8'h0C, 8'hAA, 8'h78, 8'h00, 8'h00, 8'hFF, 8'h03, 8'h51,
                                8'h3F, 8'h00, 8'h00, 8'h04, 8'h04, 8'h04, 8'h04, 8'h04,
                                8'h04, 8'h0A, 8'h0A, 8'h00, 8'h00, 8'h00, 8'hC0, 8'h34,
                                8'h07, 8'h44, 8'h1F, 8'h00};

  always #(CLK_PERIOD / 2) clk = ~clk;

  codec_reg_bridge dut (
    .clk        (clk),
    .rstN       (rstN),
    .cmdWrEn    (cmdWrEn),
    .cmdWdata   (cmdWdata),
    .cmdRdata   (cmdRdata),
    .dataRdata  (dataRdata),
    .rampUpPulse(rampUpPulse),
    .rampDnPulse(rampDnPulse)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Returns at the negedge after the accepting edge
  task automatic issueCmd(input logic wr, input logic [6:0] addr, input logic [7:0] data);
    @(negedge clk);
    cmdWrEn  = 1'b1;
    cmdWdata = {15'd0, wr, 1'b0, addr, data};
    @(negedge clk);
    cmdWrEn  = 1'b0;
    cmdWdata = '0;
  endtask

  task automatic readReg(input logic [6:0] addr, output logic [7:0] val);
    issueCmd(1'b0, addr, 8'h00);
    waitEdges(6);
    val = dataRdata[7:0];
  endtask

  task automatic writeReg(input logic [6:0] addr, input logic [7:0] data);
    issueCmd(1'b1, addr, data);
    waitEdges(4);
    check("R2", "busy clear after write", {31'd0, cmdRdata[16]}, 32'd0);
  endtask

  task automatic testReset();
    logic [7:0] v;
    check("R5", "command window after reset", cmdRdata, 32'd0);
    check("R5", "read window after reset", dataRdata, 32'd0);
    for (int a = 0; a < 28; a++) begin
      readReg(7'(a), v);
      if (a == 20 || a == 21) check("R6", $sformatf("test entry %0d", a), {24'd0, v}, 32'd0);
      else check("R5", $sformatf("default of entry %0d", a), {24'd0, v}, {24'd0, defaults[a]});
    end
  endtask

  task automatic testWriteTiming();
    logic [7:0] v;
    issueCmd(1'b1, 7'd3, 8'h5A);
    check("R1", "command fields while busy", cmdRdata, {15'd0, 1'b1, 1'b0, 7'd3, 8'h5A});
    waitEdges(3);
    check("R2", "busy still set after 3rd edge", {31'd0, cmdRdata[16]}, 32'd1);
    waitEdges(1);
    check("R2", "busy clear after 4th edge", {31'd0, cmdRdata[16]}, 32'd0);
    readReg(7'd3, v);
    check("R2", "committed byte", {24'd0, v}, 32'h5A);
  endtask

  task automatic testBusyIgnore();
    logic [7:0] v;
    issueCmd(1'b1, 7'd4, 8'h11);
    issueCmd(1'b1, 7'd5, 8'h22);
    check("R3", "fields kept during busy", cmdRdata[14:0], {7'd4, 8'h11});
    waitEdges(4);
    readReg(7'd5, v);
    check("R3", "ignored write left entry 5", {24'd0, v}, 32'hFF);
    readReg(7'd4, v);
    check("R3", "accepted write to entry 4", {24'd0, v}, 32'h11);
  endtask

  task automatic testReadLatency();
    logic [7:0] v;
    readReg(7'd1, v);
    issueCmd(1'b0, 7'd7, 8'h00);
    check("R1", "address-only command fields", cmdRdata, {15'd0, 1'b0, 1'b0, 7'd7, 8'h00});
    waitEdges(5);
    check("R4", "old byte through 5th edge", {24'd0, dataRdata[7:0]}, 32'hAA);
    waitEdges(1);
    check("R4", "new byte at 6th edge", {24'd0, dataRdata[7:0]}, 32'h51);
  endtask

  task automatic testBlocked();
    logic [7:0] v;
    writeReg(7'd20, 8'h77);
    readReg(7'd20, v);
    check("R6", "write to entry 20 discarded", {24'd0, v}, 32'd0);
    writeReg(7'd30, 8'h66);
    readReg(7'd30, v);
    check("R6", "out-of-range read", {24'd0, v}, 32'd0);
    readReg(7'd127, v);
    check("R6", "top address read", {24'd0, v}, 32'd0);
    readReg(7'd19, v);
    check("R6", "neighbour entry 19 untouched", {24'd0, v}, 32'd0);
  endtask

  task automatic testStatus();
    logic [7:0] v;
    check("R8", "irq low at start", {31'd0, dataRdata[8]}, 32'd0);
    @(negedge clk); rampUpPulse = 1'b1;
    @(negedge clk); rampUpPulse = 1'b0;
    check("R8", "irq after ramp-up pulse", {31'd0, dataRdata[8]}, 32'd1);
    readReg(7'd9, v);
    check("R7", "ramp-up flag held", {24'd0, v}, 32'h08);
    @(negedge clk); rampDnPulse = 1'b1;
    @(negedge clk); rampDnPulse = 1'b0;
    readReg(7'd9, v);
    check("R7", "both flags held", {24'd0, v}, 32'h0C);
    writeReg(7'd9, 8'h04);
    readReg(7'd9, v);
    check("R7", "ramp-up flag cleared by 0", {24'd0, v}, 32'h04);
    check("R8", "irq with ramp-down only", {31'd0, dataRdata[8]}, 32'd1);
    writeReg(7'd9, 8'h00);
    check("R8", "irq low after clear", {31'd0, dataRdata[8]}, 32'd0);
    issueCmd(1'b1, 7'd9, 8'h00);
    waitEdges(3);
    rampUpPulse = 1'b1;
    @(negedge clk); rampUpPulse = 1'b0;
    readReg(7'd9, v);
    check("R7", "pulse wins over same-cycle clear", {24'd0, v}, 32'h08);
    writeReg(7'd9, 8'h00);
  endtask

  task automatic testStable();
    logic [7:0] v;
    readReg(7'd26, v);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check("R9", "repeated fetch", {24'd0, dataRdata[7:0]}, 32'h1F);
    end
  endtask

  initial begin
    waitEdges(3);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWriteTiming();
    testBusyIgnore();
    testReadLatency();
    testBlocked();
    testStatus();
    testStable();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    testCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule